// File: doc/BRIEF.md
# Programmable Logic Output Macrocell

This block is one output cell of a sum-of-products programmable logic device. The AND-OR array outside the cell supplies the sum terms. The cell gets several data sum terms, which it merges by wired-OR, and separate sum terms for the clock, preset, clear and output enable. A single storage element works as a D-type or as a toggle register. Its clock comes either from its own clock sum term or from one of the dedicated register clock pins.

An output selector drives the pad from the register or from the combinational term. The pad value goes back to the array through an optional transparent input latch, which is gated by one of the dedicated latch clock pins. When the `HAS_PIN` parameter is 0, the cell becomes a buried cell. It has no pad, and only its register and combinational feedback reach the array. The configuration inputs are static while the cell runs. The power-on input `por_n` clears the register.

Top module: `plm_cell`

## Requirements
- R1: `fb_comb` is the OR of all bits of `sum_d`. Any bit at 1 makes it 1.
- R2: With `cfg_tff`=0 (D mode), `fb_reg` takes the value of `fb_comb` on each rising edge of the selected register clock.
- R3: With `cfg_tff`=1 (toggle mode), `fb_reg` inverts on a rising clock edge when `fb_comb` is 1 and holds its value when `fb_comb` is 0.
- R4: With `cfg_clk_pin`=1, the register clock is `clk_pin[cfg_clk_idx]`, and edges on the other clock pins have no effect. With `cfg_clk_pin`=0, the register clock is `sum_clk`.
- R5: `sum_set`=1 forces `fb_reg` to 1 and `sum_clr`=1 forces it to 0, with no clock edge needed.
- R6: `sum_clr` wins over `sum_set` and over a clock edge in the same cycle. While it is high, `fb_reg` stays 0.
- R7: With `cfg_out_comb`=1, `pin_out` equals `fb_comb`. With `cfg_out_comb`=0, it equals `fb_reg`.
- R8: `pin_oe` follows `sum_oe`. While `sum_oe` is 0, the pad value is `pin_in`, and the driven value never reaches `fb_pin`.
- R9: With `cfg_lat_en`=0, `fb_pin` equals the pad value: `pin_out` while `pin_oe` is 1, otherwise `pin_in`.
- R10: With `cfg_lat_en`=1, `fb_pin` follows the pad value while `lat_pin[cfg_lat_idx]` is 1 and holds it while that pin is 0. The other latch pins have no effect.
- R11: While `por_n` is 0, `fb_reg` is 0 whatever `sum_set` does.
- R12: With `HAS_PIN`=0, `pin_out`, `pin_oe` and `fb_pin` stay 0, and `fb_reg` behaves as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| por_n | input | 1 | Power-on clear, active low |
| clk_pin | input | NUM_CLK_PINS | Dedicated register clock pins |
| lat_pin | input | NUM_LAT_PINS | Dedicated latch clock pins |
| sum_d | input | NUM_SUM | Data sum terms, merged by wired-OR |
| sum_clk | input | 1 | Clock sum term |
| sum_set | input | 1 | Asynchronous preset sum term |
| sum_clr | input | 1 | Asynchronous clear sum term |
| sum_oe | input | 1 | Output enable sum term |
| cfg_tff | input | 1 | 0 = D register, 1 = toggle register |
| cfg_clk_pin | input | 1 | 1 = clock from dedicated pin, 0 = clock from sum term |
| cfg_clk_idx | input | CLK_SEL_W | Dedicated clock pin index |
| cfg_out_comb | input | 1 | 1 = pad driven by combinational term |
| cfg_lat_en | input | 1 | Input latch enable |
| cfg_lat_idx | input | LAT_SEL_W | Latch clock pin index |
| pin_in | input | 1 | Value present on the pad from outside |
| pin_out | output | 1 | Value driven toward the pad |
| pin_oe | output | 1 | Pad driver enable |
| fb_reg | output | 1 | Register feedback to the array |
| fb_comb | output | 1 | Combinational feedback to the array |
| fb_pin | output | 1 | Pad feedback to the array, latched or direct |

## Verification
The asynchronous clear or preset can arrive in the same cycle as a rising edge of the selected register clock. The bench raises `sum_clr` and holds it across a dedicated-pin edge while `fb_comb` is 1. It expects `fb_reg` to stay 0. It then holds `sum_set` across an edge while `fb_comb` is 0 and expects 1. Both results are sampled two nanoseconds after the edge, so the outcome shows whether the asynchronous term won over the captured data.

// File: rtl/plm_pkg.sv
package plm_pkg;

   typedef enum logic {
      KIND_D = 1'b0,
      KIND_T = 1'b1
   } reg_kind_e;

   typedef enum logic {
      CKSRC_TERM = 1'b0,
      CKSRC_PIN  = 1'b1
   } clk_src_e;

   function automatic int sel_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   function automatic reg_kind_e to_kind(input logic t);
      return t ? KIND_T : KIND_D;
   endfunction

   function automatic clk_src_e to_src(input logic p);
      return p ? CKSRC_PIN : CKSRC_TERM;
   endfunction

endpackage

// File: rtl/plm_sum_or.sv
module plm_sum_or #(
   parameter int NUM_SUM = 2
) (
   input  logic [NUM_SUM-1:0] terms,
   output logic               merged
);
   if (NUM_SUM < 1) begin : g_bad_width
      $error("plm_sum_or: NUM_SUM must be at least 1");
   end

   logic [NUM_SUM-1:0] chain;

   for (genvar i = 0; i < NUM_SUM; i++) begin : g_or
      if (i == 0) begin : g_first
         assign chain[i] = terms[i];
      end else begin : g_next
         assign chain[i] = chain[i-1] | terms[i];
      end
   end

   assign merged = chain[NUM_SUM-1];
endmodule

// File: rtl/plm_reg.sv
module plm_reg
   import plm_pkg::*;
#(
   parameter int NUM_CLK_PINS = 4,
   localparam int CLK_SEL_W   = sel_width(NUM_CLK_PINS)
) (
   input  logic                    por_n,
   input  logic [NUM_CLK_PINS-1:0] clk_pin,
   input  logic                    sum_clk,
   input  logic                    set_term,
   input  logic                    clr_term,
   input  logic                    d_term,
   input  logic                    cfg_tff,
   input  logic                    cfg_clk_pin,
   input  logic [CLK_SEL_W-1:0]    cfg_clk_idx,
   output logic                    ck_used,
   output logic                    q
);
   if (NUM_CLK_PINS < 1) begin : g_bad_pins
      $error("plm_reg: NUM_CLK_PINS must be at least 1");
   end

   reg_kind_e kind;
   clk_src_e  src;
   logic      pin_ck;
   logic      clr_any;
   logic      nxt;

   assign kind = to_kind(cfg_tff);
   assign src  = to_src(cfg_clk_pin);

   if (NUM_CLK_PINS == 1) begin : g_one_pin
      logic unused_idx;
      assign unused_idx = ^cfg_clk_idx;
      assign pin_ck = clk_pin[0];
   end else begin : g_many_pins
      assign pin_ck = clk_pin[cfg_clk_idx];
   end

   assign ck_used = (src == CKSRC_PIN) ? pin_ck : sum_clk;
   assign clr_any = clr_term | ~por_n;

   always_comb begin
      unique case (kind)
         KIND_T:  nxt = q ^ d_term;
         default: nxt = d_term;
      endcase
   end

   always_ff @(posedge ck_used or posedge clr_any or posedge set_term) begin
      if (clr_any) begin
         q <= 1'b0;
      end else if (set_term) begin
         q <= 1'b1;
      end else begin
         q <= nxt;
      end
   end
endmodule

// File: rtl/plm_in_latch.sv
module plm_in_latch
   import plm_pkg::*;
#(
   parameter int NUM_LAT_PINS = 4,
   localparam int LAT_SEL_W   = sel_width(NUM_LAT_PINS)
) (
   input  logic [NUM_LAT_PINS-1:0] lat_pin,
   input  logic                    cfg_lat_en,
   input  logic [LAT_SEL_W-1:0]    cfg_lat_idx,
   input  logic                    pad,
   output logic                    fb
);
   if (NUM_LAT_PINS < 1) begin : g_bad_pins
      $error("plm_in_latch: NUM_LAT_PINS must be at least 1");
   end

   logic gate;
   logic held;

   if (NUM_LAT_PINS == 1) begin : g_one_pin
      logic unused_idx;
      assign unused_idx = ^cfg_lat_idx;
      assign gate = lat_pin[0];
   end else begin : g_many_pins
      assign gate = lat_pin[cfg_lat_idx];
   end

   always_latch begin
      if (gate) begin
         held <= pad;
      end
   end

   assign fb = cfg_lat_en ? held : pad;
endmodule

// File: rtl/plm_pin_drv.sv
module plm_pin_drv #(
   parameter bit HAS_PIN = 1'b1
) (
   input  logic q,
   input  logic comb,
   input  logic cfg_out_comb,
   input  logic oe_term,
   input  logic pin_in,
   output logic pin_out,
   output logic pin_oe,
   output logic pad
);
   if (HAS_PIN) begin : g_pad
      assign pin_out = cfg_out_comb ? comb : q;
      assign pin_oe  = oe_term;
      assign pad     = oe_term ? pin_out : pin_in;
   end else begin : g_buried
      logic unused_sig;
      assign unused_sig = q ^ comb ^ cfg_out_comb ^ oe_term ^ pin_in;
      assign pin_out    = 1'b0;
      assign pin_oe     = 1'b0;
      assign pad        = 1'b0;
   end
endmodule

// File: rtl/plm_cell.sv
module plm_cell
   import plm_pkg::*;
#(
   parameter int NUM_CLK_PINS = 4,
   parameter int NUM_LAT_PINS = 4,
   parameter int NUM_SUM      = 2,
   parameter bit HAS_PIN      = 1'b1,
   localparam int CLK_SEL_W   = sel_width(NUM_CLK_PINS),
   localparam int LAT_SEL_W   = sel_width(NUM_LAT_PINS)
) (
   input  logic                    por_n,
   input  logic [NUM_CLK_PINS-1:0] clk_pin,
   input  logic [NUM_LAT_PINS-1:0] lat_pin,
   input  logic [NUM_SUM-1:0]      sum_d,
   input  logic                    sum_clk,
   input  logic                    sum_set,
   input  logic                    sum_clr,
   input  logic                    sum_oe,
   input  logic                    cfg_tff,
   input  logic                    cfg_clk_pin,
   input  logic [CLK_SEL_W-1:0]    cfg_clk_idx,
   input  logic                    cfg_out_comb,
   input  logic                    cfg_lat_en,
   input  logic [LAT_SEL_W-1:0]    cfg_lat_idx,
   input  logic                    pin_in,
   output logic                    pin_out,
   output logic                    pin_oe,
   output logic                    fb_reg,
   output logic                    fb_comb,
   output logic                    fb_pin
);
   logic d_or;
   logic reg_ck;
   logic pad;

   plm_sum_or #(.NUM_SUM(NUM_SUM)) u_or (
      .terms  (sum_d),
      .merged (d_or)
   );

   plm_reg #(.NUM_CLK_PINS(NUM_CLK_PINS)) u_reg (
      .por_n       (por_n),
      .clk_pin     (clk_pin),
      .sum_clk     (sum_clk),
      .set_term    (sum_set),
      .clr_term    (sum_clr),
      .d_term      (d_or),
      .cfg_tff     (cfg_tff),
      .cfg_clk_pin (cfg_clk_pin),
      .cfg_clk_idx (cfg_clk_idx),
      .ck_used     (reg_ck),
      .q           (fb_reg)
   );

   plm_pin_drv #(.HAS_PIN(HAS_PIN)) u_drv (
      .q            (fb_reg),
      .comb         (d_or),
      .cfg_out_comb (cfg_out_comb),
      .oe_term      (sum_oe),
      .pin_in       (pin_in),
      .pin_out      (pin_out),
      .pin_oe       (pin_oe),
      .pad          (pad)
   );

   if (HAS_PIN) begin : g_latch
      plm_in_latch #(.NUM_LAT_PINS(NUM_LAT_PINS)) u_lat (
         .lat_pin     (lat_pin),
         .cfg_lat_en  (cfg_lat_en),
         .cfg_lat_idx (cfg_lat_idx),
         .pad         (pad),
         .fb          (fb_pin)
      );
   end else begin : g_no_latch
      logic unused_lat;
      assign unused_lat = ^lat_pin ^ cfg_lat_en ^ ^cfg_lat_idx ^ pad;
      assign fb_pin     = 1'b0;
   end

   assign fb_comb = d_or;
endmodule

// File: rtl/plm_cell_chk.sv
module plm_cell_chk #(
   parameter bit HAS_PIN = 1'b1
) (
   input logic por_n,
   input logic ck,
   input logic d,
   input logic sum_set,
   input logic sum_clr,
   input logic cfg_tff,
   input logic cfg_out_comb,
   input logic cfg_lat_en,
   input logic pin_in,
   input logic pin_out,
   input logic pin_oe,
   input logic fb_reg,
   input logic fb_comb,
   input logic fb_pin
);
   logic async_any;
   logic hit;

   assign async_any = sum_set | sum_clr | ~por_n;

   always_ff @(posedge ck or posedge async_any) begin
      if (async_any) hit <= 1'b1;
      else           hit <= 1'b0;
   end

   // R2
   d_mode_chk: assert property (@(posedge ck) disable iff (!por_n)
      (!cfg_tff && !hit) |=> (hit || fb_reg == $past(d)));

   // R3
   t_mode_chk: assert property (@(posedge ck) disable iff (!por_n)
      (cfg_tff && !hit) |=> (hit || fb_reg == ($past(fb_reg) ^ $past(d))));

   // R6
   clr_prio_chk: assert property (@(negedge ck) disable iff (!por_n)
      sum_clr |-> !fb_reg);

   // R5
   preset_chk: assert property (@(negedge ck) disable iff (!por_n)
      (sum_set && !sum_clr) |-> fb_reg);

   // R7
   out_mux_chk: assert property (@(negedge ck) disable iff (!por_n)
      HAS_PIN |-> (pin_out == (cfg_out_comb ? fb_comb : fb_reg)));

   // R8
   oe_input_chk: assert property (@(negedge ck) disable iff (!por_n)
      (HAS_PIN && !pin_oe && !cfg_lat_en) |-> (fb_pin == pin_in));

   // R12
   buried_chk: assert property (@(negedge ck) disable iff (!por_n)
      !HAS_PIN |-> (!pin_oe && !pin_out && !fb_pin));
endmodule

bind plm_cell plm_cell_chk #(.HAS_PIN(HAS_PIN)) u_chk (
   .por_n        (por_n),
   .ck           (reg_ck),
   .d            (d_or),
   .sum_set      (sum_set),
   .sum_clr      (sum_clr),
   .cfg_tff      (cfg_tff),
   .cfg_out_comb (cfg_out_comb),
   .cfg_lat_en   (cfg_lat_en),
   .pin_in       (pin_in),
   .pin_out      (pin_out),
   .pin_oe       (pin_oe),
   .fb_reg       (fb_reg),
   .fb_comb      (fb_comb),
   .fb_pin       (fb_pin)
);

// File: tb/sim_plm_cell.sv
module sim_plm_cell;
   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic [3:0] lat_pin = 4'b0;
   logic [1:0] sum_d = 2'b0;
   logic       sum_clk = 1'b0, sum_set = 1'b0, sum_clr = 1'b0, sum_oe = 1'b0;
   logic       cfg_tff = 1'b0, cfg_clk_pin = 1'b1, cfg_out_comb = 1'b0, cfg_lat_en = 1'b0;
   logic [1:0] cfg_clk_idx = 2'd3, cfg_lat_idx = 2'd2;
   logic       pin_in = 1'b0;
   logic [3:0] clk_pin;
   logic       pin_out, pin_oe, fb_reg, fb_comb, fb_pin;
   logic       b_out, b_oe, b_reg, b_comb, b_pin;
   int         n_chk = 0, n_bad = 0;
   bit         done = 1'b0;

   assign clk_pin = {3'b000, clk};
   always #4 clk = ~clk;

   plm_cell u0 (
      .por_n(por_n), .clk_pin(clk_pin), .lat_pin(lat_pin), .sum_d(sum_d),
      .sum_clk(sum_clk), .sum_set(sum_set), .sum_clr(sum_clr), .sum_oe(sum_oe),
      .cfg_tff(cfg_tff), .cfg_clk_pin(cfg_clk_pin), .cfg_clk_idx(cfg_clk_idx),
      .cfg_out_comb(cfg_out_comb), .cfg_lat_en(cfg_lat_en), .cfg_lat_idx(cfg_lat_idx),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .fb_reg(fb_reg),
      .fb_comb(fb_comb), .fb_pin(fb_pin)
   );

   plm_cell #(.HAS_PIN(1'b0)) u1 (
      .por_n(por_n), .clk_pin(clk_pin), .lat_pin(lat_pin), .sum_d(sum_d),
      .sum_clk(sum_clk), .sum_set(sum_set), .sum_clr(sum_clr), .sum_oe(sum_oe),
      .cfg_tff(cfg_tff), .cfg_clk_pin(cfg_clk_pin), .cfg_clk_idx(cfg_clk_idx),
      .cfg_out_comb(cfg_out_comb), .cfg_lat_en(cfg_lat_en), .cfg_lat_idx(cfg_lat_idx),
      .pin_in(pin_in), .pin_out(b_out), .pin_oe(b_oe), .fb_reg(b_reg),
      .fb_comb(b_comb), .fb_pin(b_pin)
   );

   // {sum_d[1:0], sum_oe, cfg_out_comb, pin_in, exp pin_out, pin_oe, fb_comb, fb_pin}
   localparam logic [8:0] VEC [8] = '{
      9'b00_1_1_1_0_1_0_0,
      9'b01_1_1_0_1_1_1_1,
      9'b10_1_1_0_1_1_1_1,
      9'b11_0_1_0_1_0_1_0,
      9'b00_0_1_1_0_0_0_1,
      9'b11_1_0_1_0_1_1_0,
      9'b00_0_0_1_0_0_0_1,
      9'b01_0_0_0_0_0_1_0
   };

   task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic at_low();
      @(negedge clk);
      #1;
   endtask

   task automatic pulse_term_clk();
      #1 sum_clk = 1'b1;
      #1 sum_clk = 1'b0;
      #1;
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      end
   endtask

   initial begin
      #200000;
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      summary();
      $finish;
   end

   initial begin
      // R11: power-on clear beats preset
      sum_set = 1'b1;
      #20;
      chk("R11 por clears", {3'b0, fb_reg}, 4'h0);
      sum_set = 1'b0;
      #5 por_n = 1'b1;
      #5;
      chk("R11 after release", {3'b0, fb_reg}, 4'h0);

      // R1 R7 R8 R9: table walk, no register clock (pin 3 is tied low)
      for (int i = 0; i < 8; i++) begin
         {sum_d, sum_oe, cfg_out_comb, pin_in} = VEC[i][8:4];
         #2;
         chk($sformatf("R1 R7 R8 R9 vector %0d", i),
             {pin_out, pin_oe, fb_comb, fb_pin}, VEC[i][3:0]);
      end

      // R2: D mode on dedicated pin 0
      sum_oe = 1'b0; cfg_out_comb = 1'b0; sum_d = 2'b00;
      at_low(); cfg_clk_idx = 2'd0;
      sum_d = 2'b01; tick();
      chk("R2 capture 1", {3'b0, fb_reg}, 4'h1);
      chk("R12 buried register", {b_oe, b_out, b_pin, b_reg}, 4'h1);
      sum_d = 2'b00; tick();
      chk("R2 capture 0", {3'b0, fb_reg}, 4'h0);

      // R3: toggle mode
      cfg_tff = 1'b1; sum_d = 2'b10; tick();
      chk("R3 toggle up", {3'b0, fb_reg}, 4'h1);
      tick();
      chk("R3 toggle down", {3'b0, fb_reg}, 4'h0);
      sum_d = 2'b00; tick();
      chk("R3 hold", {3'b0, fb_reg}, 4'h0);
      sum_d = 2'b01; tick();
      chk("R3 toggle again", {3'b0, fb_reg}, 4'h1);

      // R4: unselected pin edges ignored, then sum-term clock
      at_low(); cfg_clk_idx = 2'd1;
      tick(); tick();
      chk("R4 other pin ignored", {3'b0, fb_reg}, 4'h1);
      at_low(); cfg_clk_pin = 1'b0; cfg_clk_idx = 2'd0; cfg_tff = 1'b0; sum_d = 2'b00;
      tick();
      chk("R4 pin edge ignored in term mode", {3'b0, fb_reg}, 4'h1);
      pulse_term_clk();
      chk("R4 term clock capture 0", {3'b0, fb_reg}, 4'h0);
      sum_d = 2'b11; pulse_term_clk();
      chk("R4 term clock capture 1", {3'b0, fb_reg}, 4'h1);

      // R5 R6: asynchronous preset and clear without clock
      sum_d = 2'b00;
      sum_clr = 1'b1; #1;
      chk("R5 async clear", {3'b0, fb_reg}, 4'h0);
      sum_clr = 1'b0; #1 sum_set = 1'b1; #1;
      chk("R5 async preset", {3'b0, fb_reg}, 4'h1);
      sum_clr = 1'b1; #1;
      chk("R6 clear beats preset", {3'b0, fb_reg}, 4'h0);
      sum_set = 1'b0; sum_clr = 1'b0; #1;

      // R6 R5: asynchronous term across a clock edge
      at_low(); cfg_clk_pin = 1'b1;
      sum_d = 2'b01; sum_clr = 1'b1; tick();
      chk("R6 clear beats edge", {3'b0, fb_reg}, 4'h0);
      sum_clr = 1'b0; sum_d = 2'b00; sum_set = 1'b1; tick();
      chk("R5 preset beats edge", {3'b0, fb_reg}, 4'h1);
      sum_set = 1'b0; tick();
      chk("R2 capture after preset", {3'b0, fb_reg}, 4'h0);

      // R10: input latch on latch pin 2, pad used as input
      at_low(); cfg_clk_idx = 2'd3;
      sum_oe = 1'b0; cfg_lat_en = 1'b1; cfg_lat_idx = 2'd2;
      lat_pin = 4'b0100; pin_in = 1'b1; #1;
      chk("R10 transparent 1", {3'b0, fb_pin}, 4'h1);
      pin_in = 1'b0; #1;
      chk("R10 transparent 0", {3'b0, fb_pin}, 4'h0);
      pin_in = 1'b1; #1;
      lat_pin = 4'b0000; #1;
      pin_in = 1'b0; #1;
      chk("R10 hold", {3'b0, fb_pin}, 4'h1);
      lat_pin = 4'b1010; #1;
      chk("R10 other latch pins ignored", {3'b0, fb_pin}, 4'h1);
      lat_pin = 4'b0000;
      cfg_lat_en = 1'b0; #1;
      chk("R9 latch bypass", {3'b0, fb_pin}, 4'h0);

      // R12: buried cell keeps its pad outputs at 0
      sum_oe = 1'b1; cfg_out_comb = 1'b1; sum_d = 2'b11; pin_in = 1'b1; #1;
      chk("R12 buried pad quiet", {1'b0, b_oe, b_out, b_pin}, 4'h0);
      chk("R1 buried comb", {3'b0, b_comb}, 4'h1);

      summary();
      $finish;
   end
endmodule